// File: doc/BRIEF.md
# Power-Budgeted BIST Session Sequencer

This block runs a fixed set of built-in self-tests as an ordered list of sessions. A session is a group of tests that may run at the same time. All tests of a session get their enables on the same clock edge. Each enable drops after that test's own length in cycles. The next session starts as soon as the longest test of the current one has finished, so there are no idle cycles between sessions.

Each test has a length and a power weight, and each session has a membership mask. All three are parameters. Every session's summed power is compared with a power limit, which is also a parameter. A session that exceeds the limit, or that has no member test, is never enabled: it is skipped and an error flag is raised. During a run the block reports busy, the index of the current session and the number of cycles elapsed. When the run ends it gives a one-cycle done pulse and a verdict that is the AND of every test's pass bit, each sampled as that test completes.

The default configuration has six tests. Test number n drives and observes bit n-1 of the per-test vectors. The (power, length) pairs are T1 (2,100), T2 (1,10), T3 (1,10), T4 (1,5), T5 (2,10) and T6 (1,100). The power limit is 4. The sessions are s0 = {T3,T4}, s1 = {T2,T5} and s2 = {T1,T6}, which run for 10, 10 and 100 cycles: 120 cycles in total. The tests that share a session use disjoint test resources. Choosing those groupings is the job of whoever writes the parameters.

Top module: `bist_session_seq`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) leaves busy, done, all_pass, pwr_err, elapsed, sess_idx and every test_en bit at 0.
- R2: A start seen while idle makes busy rise on that same edge, together with the enables of the first admissible session's tests. elapsed reads 0 in the first cycle.
- R3: Each test's enable stays high for exactly its configured length in cycles, counted from its session's launch edge (default: T4 for 5 cycles, T1 and T6 for 100).
- R4: The enables of the next admissible session rise on the same edge at which the longest test of the previous session drops. sess_idx shows the session whose tests are enabled.
- R5: The summed power weight of the tests enabled at any time never exceeds the power limit.
- R6: A session whose summed power exceeds the limit, or that has an empty mask, is skipped without any enable and sets pwr_err. pwr_err stays set until the next accepted start, which clears it unless that run skips a session again.
- R7: elapsed increases by one on each edge while busy, so after a run it holds the total session time (120 by default) until the next start.
- R8: On the edge after the last session's final enabled cycle, busy falls, all enables are low and done is high for exactly one cycle.
- R9: all_pass is set to 1 at start. It then becomes the AND of each test's test_pass bit, sampled only in that test's last enabled cycle. Values of test_pass in any other cycle have no effect.
- R10: A start seen while busy has no effect: the enables, sess_idx and elapsed continue as if start were low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a run when idle |
| test_pass | input | N_TESTS | Per-test pass bit, sampled in the test's last enabled cycle |
| test_en | output | N_TESTS | Per-test run enable |
| busy | output | 1 | A run is in progress |
| sess_idx | output | clog2(N_SESS+1) | Index of the running session |
| elapsed | output | ELAP_W | Cycles spent in the current or last run |
| done | output | 1 | One-cycle pulse at the end of a run |
| all_pass | output | 1 | Overall pass verdict |
| pwr_err | output | 1 | A session was skipped for power or emptiness |

## Verification
The enables and busy change on the edge that samples start. Each later cycle k, counted from that edge, has a known set of enables, a known session and elapsed equal to k. The bench therefore compares all of these on the falling edge after each rising edge, against tables that its own functions build from the lengths and masks. done, the final elapsed value and all_pass are due exactly one cycle after the last enabled cycle, that is at offset 120 with the default configuration and 10 with the skipping configuration. The bench samples them at that offset and confirms that done has cleared one cycle later. Pass bits are driven at each falling edge, and the expected verdict takes only the value that is present in each test's last enabled cycle.

// File: rtl/bist_session_seq.sv
module bist_session_seq #(
  parameter int N_TESTS   = 6,
  parameter int N_SESS    = 3,
  parameter int LEN_W     = 8,
  parameter int PWR_W     = 4,
  parameter int ELAP_W    = 16,
  parameter int PWR_LIMIT = 4,
  parameter logic [N_TESTS*LEN_W-1:0]  TEST_LEN  = {8'd100, 8'd10, 8'd5, 8'd10, 8'd10, 8'd100},
  parameter logic [N_TESTS*PWR_W-1:0]  TEST_PWR  = {4'd1, 4'd2, 4'd1, 4'd1, 4'd1, 4'd2},
  parameter logic [N_SESS*N_TESTS-1:0] SESS_MASK = {6'b100001, 6'b010010, 6'b001100}
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          start,
  input  logic [N_TESTS-1:0]            test_pass,
  output logic [N_TESTS-1:0]            test_en,
  output logic                          busy,
  output logic [$clog2(N_SESS+1)-1:0]   sess_idx,
  output logic [ELAP_W-1:0]             elapsed,
  output logic                          done,
  output logic                          all_pass,
  output logic                          pwr_err
);
  localparam int SW    = $clog2(N_SESS+1);
  localparam int SUM_W = PWR_W + $clog2(N_TESTS+1);

  logic [N_TESTS-1:0] mask [N_SESS];
  logic [N_SESS-1:0]  ok;
  logic [LEN_W-1:0]   cnt [N_TESTS];
  logic [N_TESTS-1:0] last, lmask;
  logic [SW-1:0]      nx_first, nx_next, launch_idx;
  logic               fin, go, launch_valid, pass_hit;

  for (genvar s = 0; s < N_SESS; s++) begin : g_sess
    logic [SUM_W-1:0] sum;
    assign mask[s] = SESS_MASK[s*N_TESTS +: N_TESTS];
    always_comb begin
      sum = '0;
      for (int i = 0; i < N_TESTS; i++)
        if (mask[s][i]) sum = sum + SUM_W'(TEST_PWR[i*PWR_W +: PWR_W]);
    end
    assign ok[s] = (sum <= SUM_W'(PWR_LIMIT)) && (|mask[s]);
  end

  for (genvar i = 0; i < N_TESTS; i++) begin : g_last
    assign last[i] = cnt[i] == LEN_W'(1);
  end

  function automatic logic [SW-1:0] pick(input logic [N_SESS-1:0] okv, input int from);
    logic [SW-1:0] res;
    res = SW'(N_SESS);
    for (int s = N_SESS-1; s >= 0; s--)
      if (s >= from && okv[s]) res = SW'(s);
    return res;
  endfunction

  assign nx_first     = pick(ok, 0);
  assign nx_next      = pick(ok, int'(sess_idx) + 1);
  assign fin          = busy && (&(~test_en | last));
  assign go           = (!busy && start) || fin;
  assign launch_idx   = busy ? nx_next : nx_first;
  assign launch_valid = launch_idx != SW'(N_SESS);
  assign pass_hit     = &(~(test_en & last) | test_pass);

  always_comb begin
    lmask = '0;
    for (int s = 0; s < N_SESS; s++)
      if (launch_idx == SW'(s)) lmask = mask[s];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      done     <= 1'b0;
      all_pass <= 1'b0;
      pwr_err  <= 1'b0;
      elapsed  <= '0;
      sess_idx <= '0;
      test_en  <= '0;
      for (int i = 0; i < N_TESTS; i++) cnt[i] <= '0;
    end else begin
      done <= 1'b0;
      if (busy) begin
        elapsed  <= elapsed + ELAP_W'(1);
        all_pass <= all_pass & pass_hit;
      end
      for (int i = 0; i < N_TESTS; i++)
        if (test_en[i]) begin
          cnt[i] <= cnt[i] - LEN_W'(1);
          if (last[i]) test_en[i] <= 1'b0;
        end
      if (go) begin
        if (!busy) begin
          elapsed  <= '0;
          all_pass <= 1'b1;
          pwr_err  <= nx_first != '0;
        end else if (int'(nx_next) != int'(sess_idx) + 1) begin
          pwr_err <= 1'b1;
        end
        if (launch_valid) begin
          busy     <= 1'b1;
          sess_idx <= launch_idx;
          test_en  <= lmask;
          for (int i = 0; i < N_TESTS; i++)
            if (lmask[i]) cnt[i] <= TEST_LEN[i*LEN_W +: LEN_W];
        end else begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/bist_session_seq_chk.sv
module bist_session_seq_chk #(
  parameter int N_TESTS   = 6,
  parameter int PWR_W     = 4,
  parameter int ELAP_W    = 16,
  parameter int PWR_LIMIT = 4,
  parameter logic [N_TESTS*PWR_W-1:0] TEST_PWR = '0
) (
  input logic               clk,
  input logic               rst,
  input logic               start,
  input logic               busy,
  input logic               done,
  input logic [N_TESTS-1:0] test_en,
  input logic [ELAP_W-1:0]  elapsed
);
  int en_pwr;
  always_comb begin
    en_pwr = 0;
    for (int i = 0; i < N_TESTS; i++)
      if (test_en[i]) en_pwr = en_pwr + int'(TEST_PWR[i*PWR_W +: PWR_W]);
  end

  assert_reset_idle_R1: assert property (@(posedge clk) rst |=> (!busy && test_en == '0 && !done));
  assert_launch_enables_R2: assert property (@(posedge clk) disable iff (rst) $rose(busy) |-> test_en != '0);
  assert_power_budget_R5: assert property (@(posedge clk) disable iff (rst) en_pwr <= PWR_LIMIT);
  assert_elapsed_step_R7: assert property (@(posedge clk) disable iff (rst) busy |=> elapsed == $past(elapsed) + ELAP_W'(1));
  assert_idle_no_enable_R8: assert property (@(posedge clk) disable iff (rst) !busy |-> test_en == '0);
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst) done |=> !done);
  assert_done_not_busy_R8: assert property (@(posedge clk) disable iff (rst) done |-> !busy);
  assert_start_ignored_R10: assert property (@(posedge clk) disable iff (rst) (busy && start) |=> elapsed != '0);
endmodule

bind bist_session_seq bist_session_seq_chk #(
  .N_TESTS(N_TESTS), .PWR_W(PWR_W), .ELAP_W(ELAP_W),
  .PWR_LIMIT(PWR_LIMIT), .TEST_PWR(TEST_PWR)
) chk_i (
  .clk(clk), .rst(rst), .start(start), .busy(busy),
  .done(done), .test_en(test_en), .elapsed(elapsed)
);

// File: tb/bist_session_seq_tb.sv
module bist_session_seq_tb_top;
  localparam int NT = 6;
  localparam int NS = 3;
  localparam logic [17:0] GOOD_M = {6'b100001, 6'b010010, 6'b001100};
  localparam logic [17:0] BAD_M  = {6'b010011, 6'b001100, 6'b110001};
  localparam int LENS [NT] = '{100, 10, 10, 5, 10, 100};
  localparam int PWRS [NT] = '{2, 1, 1, 1, 2, 1};

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst, start, start_b;
  logic [NT-1:0] tp;
  logic [NT-1:0] en_g, en_b;
  logic busy_g, busy_b, done_g, done_b, ap_g, ap_b, err_g, err_b;
  logic [1:0] sess_g, sess_b;
  logic [15:0] el_g, el_b;

  bist_session_seq dut_i (
    .clk(clk), .rst(rst), .start(start), .test_pass(tp), .test_en(en_g),
    .busy(busy_g), .sess_idx(sess_g), .elapsed(el_g), .done(done_g),
    .all_pass(ap_g), .pwr_err(err_g));

  bist_session_seq #(.SESS_MASK(BAD_M)) dut_bad_i (
    .clk(clk), .rst(rst), .start(start_b), .test_pass(tp), .test_en(en_b),
    .busy(busy_b), .sess_idx(sess_b), .elapsed(el_b), .done(done_b),
    .all_pass(ap_b), .pwr_err(err_b));

  int checks = 0, failures = 0, wd = 0;
  bit finished = 0;

  function automatic bit sok(logic [17:0] m, int s);
    int sum = 0;
    for (int i = 0; i < NT; i++) if (m[s*NT+i]) sum += PWRS[i];
    return sum <= 4 && m[s*NT +: NT] != 0;
  endfunction

  function automatic int smax(logic [17:0] m, int s);
    int mx = 0;
    for (int i = 0; i < NT; i++) if (m[s*NT+i] && LENS[i] > mx) mx = LENS[i];
    return mx;
  endfunction

  function automatic int soff(logic [17:0] m, int s);
    int off = 0;
    for (int j = 0; j < s; j++) if (sok(m, j)) off += smax(m, j);
    return off;
  endfunction

  function automatic logic [NT-1:0] exp_en(logic [17:0] m, int k);
    logic [NT-1:0] e = '0;
    for (int s = 0; s < NS; s++)
      if (sok(m, s))
        for (int i = 0; i < NT; i++)
          if (m[s*NT+i] && k >= soff(m, s) && k < soff(m, s) + LENS[i]) e[i] = 1'b1;
    return e;
  endfunction

  function automatic int exp_sess(logic [17:0] m, int k);
    for (int s = 0; s < NS; s++)
      if (sok(m, s) && k >= soff(m, s) && k < soff(m, s) + smax(m, s)) return s;
    return -1;
  endfunction

  function automatic int last_k(logic [17:0] m, int i);
    for (int s = 0; s < NS; s++)
      if (sok(m, s) && m[s*NT+i]) return soff(m, s) + LENS[i] - 1;
    return -1;
  endfunction

  function automatic int psum(logic [NT-1:0] v);
    int p = 0;
    for (int i = 0; i < NT; i++) if (v[i]) p += PWRS[i];
    return p;
  endfunction

  task automatic chk(input bit good, input string req, input longint act, input longint exp);
    checks++;
    if (!good) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_good(input int mode);
    int t;
    logic exp_pass;
    logic [NT-1:0] e;
    t = soff(GOOD_M, NS);
    exp_pass = 1'b1;
    @(negedge clk);
    start = 1'b1;
    for (int k = 0; k <= t + 1; k++) begin
      @(negedge clk);
      if (k < t) begin
        e = exp_en(GOOD_M, k);
        chk(en_g == e, "R3 R4 enables", en_g, e);
        chk(sess_g == exp_sess(GOOD_M, k), "R4 session index", sess_g, exp_sess(GOOD_M, k));
        chk(busy_g, "R2 busy", busy_g, 1);
        chk(el_g == k, "R7 elapsed", el_g, k);
        chk(psum(en_g) <= 4, "R5 power", psum(en_g), 4);
        chk(!err_g, "R6 no error", err_g, 0);
        for (int i = 0; i < NT; i++)
          if (mode == 0) tp[i] = 1'b1;
          else if (mode == 1) tp[i] = ($urandom % 6) != 0;
          else tp[i] = (last_k(GOOD_M, i) == k);
        for (int i = 0; i < NT; i++)
          if (last_k(GOOD_M, i) == k) exp_pass = exp_pass & tp[i];
        start = (mode == 1) ? (($urandom % 4) == 0) : 1'b0; // R10 stimulus
      end else if (k == t) begin
        start = 1'b0;
        chk(!busy_g, "R8 busy low", busy_g, 0);
        chk(done_g, "R8 done", done_g, 1);
        chk(en_g == 0, "R8 enables low", en_g, 0);
        chk(el_g == t, "R7 total", el_g, t);
        chk(ap_g == exp_pass, "R9 verdict", ap_g, exp_pass);
      end else begin
        chk(!done_g, "R8 pulse width", done_g, 0);
        chk(el_g == t, "R7 hold", el_g, t);
        chk(!busy_g, "R10 no restart", busy_g, 0);
      end
    end
  endtask

  task automatic check_reset_state();
    chk(!busy_g && !done_g, "R1 busy/done", {busy_g, done_g}, 0);
    chk(en_g == 0, "R1 enables", en_g, 0);
    chk(el_g == 0 && sess_g == 0, "R1 elapsed/session", el_g, 0);
    chk(!ap_g && !err_g, "R1 pass/err", {ap_g, err_g}, 0);
  endtask

  task automatic run_bad();
    int t;
    logic [NT-1:0] e;
    t = soff(BAD_M, NS);
    tp = '1;
    @(negedge clk);
    start_b = 1'b1;
    for (int k = 0; k <= t; k++) begin
      @(negedge clk);
      start_b = 1'b0;
      chk(err_b, "R6 error flag", err_b, 1);
      if (k < t) begin
        e = exp_en(BAD_M, k);
        chk(en_b == e, "R6 skipped sessions", en_b, e);
        chk(sess_b == 1, "R6 session index", sess_b, 1);
      end else begin
        chk(done_b && !busy_b, "R6 done after skip", {done_b, busy_b}, 2);
        chk(el_b == t, "R6 elapsed", el_b, t);
        chk(ap_b, "R9 verdict", ap_b, 1);
      end
    end
  endtask

  initial begin
    void'($urandom(32'd4242));
    rst = 1'b1; start = 1'b0; start_b = 1'b0; tp = '1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    check_reset_state();
    run_good(0);
    run_good(1);
    run_good(2);
    run_good(1);
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (14) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check_reset_state();
    run_bad();
    run_good(0);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  always @(posedge clk) begin
    wd++;
    if (wd == 100000 && !finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", wd, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule